// File: doc/BRIEF.md
# Tracking Fault Monitor

The block decides each clock cycle whether a tracking angle converter can be trusted and drives one active-high fault flag. It takes the loop's signed angle error, the selected output resolution (16-bit fine or 14-bit coarse), and three alarm flags: signal amplitude lost, reference lost, and over-velocity. Any alarm, or an error too large for the selected resolution, raises the flag on the next clock edge.

The error is always presented in 16-bit LSB units. The null limit is 180 LSBs of the selected resolution. In coarse mode that is 180 coarse LSBs, which is 720 in the input's units. Once raised, the flag stays high until the loop has shown a clean null for a run of consecutive clocks. Reset is treated the same way, so downstream logic never sees a healthy flag before the loop has proved itself.

Top module: `tracking_fault_monitor`

## Requirements
- R1: `fault` is 1 for "untrustworthy" and 0 for "healthy". Asserting `rst_n` low forces `fault` to 1 at once, without waiting for a clock edge.
- R2: `loop_err` is a signed two's-complement error in 16-bit LSB units. With `res_coarse` = 0 (16-bit mode), a sample with |loop_err| > 180 sets `fault` on that clock edge. A sample with |loop_err| = 180 does not.
- R3: With `res_coarse` = 1 (14-bit mode), the limit is 720. A sample with |loop_err| > 720 sets `fault`, and one with |loop_err| <= 720 does not.
- R4: The most negative `loop_err` value (-32768 at the default width) counts as exceeding the limit in either mode.
- R5: A sample with `sig_lost` = 1 sets `fault` on that clock edge.
- R6: A sample with `ref_lost` = 1 sets `fault` on that clock edge.
- R7: A sample with `overspeed` = 1 sets `fault` on that clock edge, and `fault` stays 1 for as long as the alarm persists.
- R8: A "good" sample is one with no alarm and the error within the limit. `fault` falls to 0 on the edge that completes SETTLE_CYCLES consecutive good samples (default 16). A single bad sample restarts the count.
- R9: After reset is released, `fault` stays 1 for SETTLE_CYCLES - 1 good edges and falls on the SETTLE_CYCLES-th good edge.
- R10: While `fault` is 0, it stays 0 for as long as every sample is good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| loop_err | input | ERR_W (16) | Signed loop error in 16-bit LSB units |
| res_coarse | input | 1 | 0 selects 16-bit resolution, 1 selects 14-bit resolution |
| sig_lost | input | 1 | Signal amplitude lost |
| ref_lost | input | 1 | Reference lost |
| overspeed | input | 1 | Loop cannot keep up with the input rate |
| fault | output | 1 | 1 while the converter output cannot be trusted |

## Verification
A wrong magnitude or threshold path shows up on the first edge after a boundary error value is applied: `fault` either fails to rise or rises when it should not. A wrong settle counter shows up as a fall that comes one or more edges early or late against a known run of good samples. A counter that is not restarted by a single bad sample lets `fault` drop too soon after an interrupted run. Both are visible within SETTLE_CYCLES + 1 edges of the stimulus.

// File: rtl/tfm_pkg.sv
package tfm_pkg;

  typedef enum logic {
    RES_FINE   = 1'b0,
    RES_COARSE = 1'b1
  } res_mode_e;

  localparam int NUM_MODES = 2;

  // Bits of angle resolution carried by each mode.
  function automatic int mode_bits(input int idx, input int fine_bits, input int coarse_bits);
    return (idx == int'(RES_COARSE)) ? coarse_bits : fine_bits;
  endfunction

endpackage

// File: rtl/tfm_err_mag.sv
module tfm_err_mag #(
  parameter int ERR_W = 16
) (
  input  logic signed [ERR_W-1:0] err_in,
  output logic        [ERR_W-1:0] mag_out
);

  // The magnitude of the most negative value is 2^(ERR_W-1), which still fits unsigned.
  logic [ERR_W-1:0] neg_err;

  always_comb begin
    neg_err = ~err_in + ERR_W'(1);
    mag_out = err_in[ERR_W-1] ? neg_err : err_in;
  end

endmodule

// File: rtl/tfm_thresh_cmp.sv
module tfm_thresh_cmp
  import tfm_pkg::*;
#(
  parameter int ERR_W       = 16,
  parameter int THR_LSB     = 180,
  parameter int FINE_BITS   = 16,
  parameter int COARSE_BITS = 14
) (
  input  logic [ERR_W-1:0] mag_in,
  input  res_mode_e        mode,
  output logic             over_limit
);

  logic [NUM_MODES-1:0] over_by_mode;

  // One comparator per mode. Each limit is scaled to fine-LSB units.
  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    localparam int SHIFT   = FINE_BITS - mode_bits(m, FINE_BITS, COARSE_BITS);
    localparam int LIMIT   = THR_LSB * (1 << SHIFT);
    localparam logic [ERR_W:0] LIMIT_V = (ERR_W+1)'(LIMIT);
    assign over_by_mode[m] = {1'b0, mag_in} > LIMIT_V;
  end

  assign over_limit = over_by_mode[mode];

endmodule

// File: rtl/tfm_settle_ctr.sv
module tfm_settle_ctr #(
  parameter int SETTLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bad_now,
  output logic window_done
);

  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             at_last;

  // The count saturates at LAST, so a long good run keeps window_done high.
  always_comb begin
    at_last     = (cnt_q == LAST);
    window_done = !bad_now && at_last;
    cnt_en      = bad_now || !at_last;
    cnt_d       = bad_now ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/tracking_fault_monitor.sv
module tracking_fault_monitor
  import tfm_pkg::*;
#(
  parameter int ERR_W         = 16,
  parameter int THR_LSB       = 180,
  parameter int FINE_BITS     = 16,
  parameter int COARSE_BITS   = 14,
  parameter int SETTLE_CYCLES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [ERR_W-1:0] loop_err,
  input  logic                    res_coarse,
  input  logic                    sig_lost,
  input  logic                    ref_lost,
  input  logic                    overspeed,
  output logic                    fault
);

  res_mode_e        mode;
  logic [ERR_W-1:0] err_mag;
  logic             err_over;
  logic             bad_now;
  logic             window_done;
  logic             fault_q, fault_d, fault_en;

  assign mode = res_mode_e'(res_coarse);

  tfm_err_mag #(.ERR_W(ERR_W)) u_mag (
    .err_in  (loop_err),
    .mag_out (err_mag)
  );

  tfm_thresh_cmp #(
    .ERR_W       (ERR_W),
    .THR_LSB     (THR_LSB),
    .FINE_BITS   (FINE_BITS),
    .COARSE_BITS (COARSE_BITS)
  ) u_cmp (
    .mag_in     (err_mag),
    .mode       (mode),
    .over_limit (err_over)
  );

  assign bad_now = err_over || sig_lost || ref_lost || overspeed;

  tfm_settle_ctr #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk         (clk),
    .rst_n       (rst_n),
    .bad_now     (bad_now),
    .window_done (window_done)
  );

  // A bad sample sets the flag. Only a completed good window clears it.
  always_comb begin
    fault_en = bad_now || window_done;
    fault_d  = bad_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b1;
    end else if (fault_en) begin
      fault_q <= fault_d;
    end
  end

  assign fault = fault_q;

endmodule

// File: rtl/tracking_fault_monitor_chk.sv
module tracking_fault_monitor_chk #(
  parameter int ERR_W         = 16,
  parameter int THR_LSB       = 180,
  parameter int FINE_BITS     = 16,
  parameter int COARSE_BITS   = 14,
  parameter int SETTLE_CYCLES = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic signed [ERR_W-1:0] loop_err,
  input logic                    res_coarse,
  input logic                    sig_lost,
  input logic                    ref_lost,
  input logic                    overspeed,
  input logic                    fault
);

  localparam longint FINE_LIM   = THR_LSB;
  localparam longint COARSE_LIM = longint'(THR_LSB) * (longint'(1) << (FINE_BITS - COARSE_BITS));
  localparam int     RUN_W      = $clog2(SETTLE_CYCLES + 1) + 1;

  longint      err_val;
  logic        fine_over, coarse_over, good_smp;
  logic [RUN_W-1:0] run_q;

  always_comb begin
    err_val     = longint'(loop_err);
    fine_over   = (err_val > FINE_LIM) || (err_val < -FINE_LIM);
    coarse_over = (err_val > COARSE_LIM) || (err_val < -COARSE_LIM);
    good_smp    = !(sig_lost || ref_lost || overspeed ||
                    (res_coarse ? coarse_over : fine_over));
  end

  // Independent count of consecutive good samples, saturating at SETTLE_CYCLES.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!good_smp) begin
      run_q <= '0;
    end else if (run_q < RUN_W'(SETTLE_CYCLES)) begin
      run_q <= run_q + RUN_W'(1);
    end
  end

  // R2
  fine_err_sets_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_coarse && fine_over) |=> fault);

  // R3
  coarse_err_sets_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_coarse && coarse_over) |=> fault);

  // R5
  sig_lost_sets_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sig_lost |=> fault);

  // R6
  ref_lost_sets_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_lost |=> fault);

  // R7
  overspeed_sets_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overspeed |=> fault);

  // R8
  clear_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault) |-> (run_q >= RUN_W'(SETTLE_CYCLES)));

  // R9
  reset_exit_faulted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> fault);

  // R10
  healthy_stays_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault && good_smp) |=> !fault);

endmodule

bind tracking_fault_monitor tracking_fault_monitor_chk #(
  .ERR_W         (ERR_W),
  .THR_LSB       (THR_LSB),
  .FINE_BITS     (FINE_BITS),
  .COARSE_BITS   (COARSE_BITS),
  .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .loop_err   (loop_err),
  .res_coarse (res_coarse),
  .sig_lost   (sig_lost),
  .ref_lost   (ref_lost),
  .overspeed  (overspeed),
  .fault      (fault)
);

// File: tb/tracking_fault_monitor_bench.sv
`timescale 1ns/1ps
module tracking_fault_monitor_bench;

  localparam int SETTLE = 16;
  localparam int NVEC   = 14;

  typedef struct packed {
    logic               coarse;
    logic signed [15:0] err;
    logic               los;
    logic               lor;
    logic               ovr;
    logic               exp_fault;
  } vec_t;

  // Each vector is applied for one edge from a settled state; exp_fault is the flag after that edge.
  localparam vec_t VTAB [NVEC] = '{
    '{1'b0,  16'sd0,     1'b0, 1'b0, 1'b0, 1'b0},  // R2 null
    '{1'b0,  16'sd180,   1'b0, 1'b0, 1'b0, 1'b0},  // R2 on the limit
    '{1'b0,  16'sd181,   1'b0, 1'b0, 1'b0, 1'b1},  // R2 just over
    '{1'b0, -16'sd180,   1'b0, 1'b0, 1'b0, 1'b0},  // R2 negative on the limit
    '{1'b0, -16'sd181,   1'b0, 1'b0, 1'b0, 1'b1},  // R2 negative just over
    '{1'b1,  16'sd720,   1'b0, 1'b0, 1'b0, 1'b0},  // R3 on the limit
    '{1'b1,  16'sd721,   1'b0, 1'b0, 1'b0, 1'b1},  // R3 just over
    '{1'b1, -16'sd721,   1'b0, 1'b0, 1'b0, 1'b1},  // R3 negative just over
    '{1'b1,  16'sd500,   1'b0, 1'b0, 1'b0, 1'b0},  // R3 over the fine limit but within coarse
    '{1'b0, -16'sd32768, 1'b0, 1'b0, 1'b0, 1'b1},  // R4 most negative value
    '{1'b1, -16'sd32768, 1'b0, 1'b0, 1'b0, 1'b1},  // R4 most negative value, coarse
    '{1'b0,  16'sd3,     1'b1, 1'b0, 1'b0, 1'b1},  // R5
    '{1'b1,  16'sd0,     1'b0, 1'b1, 1'b0, 1'b1},  // R6
    '{1'b0, -16'sd5,     1'b0, 1'b0, 1'b1, 1'b1}   // R7
  };

  logic               clk = 1'b0;
  logic               rst_n;
  logic signed [15:0] loop_err;
  logic               res_coarse, sig_lost, ref_lost, overspeed;
  logic               fault;

  int tests = 0;
  int fails = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  tracking_fault_monitor u_tracking_fault_monitor (
    .clk        (clk),
    .rst_n      (rst_n),
    .loop_err   (loop_err),
    .res_coarse (res_coarse),
    .sig_lost   (sig_lost),
    .ref_lost   (ref_lost),
    .overspeed  (overspeed),
    .fault      (fault)
  );

  task automatic check(input logic got, input logic exp, input string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: fault=%0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic drive(input logic c, input logic signed [15:0] e,
                       input logic s, input logic r, input logic o);
    res_coarse = c; loop_err = e; sig_lost = s; ref_lost = r; overspeed = o;
  endtask

  // Hold good inputs long enough to complete a window, then confirm the flag is clear.
  task automatic settle(input string tag);
    drive(1'b0, 16'sd0, 1'b0, 1'b0, 1'b0);
    repeat (SETTLE + 1) @(negedge clk);
    check(fault, 1'b0, tag);
  endtask

  function automatic string vtag(input vec_t v);
    if (v.los) return "R5";
    if (v.lor) return "R6";
    if (v.ovr) return "R7";
    if (v.err == -16'sd32768) return "R4";
    if (v.coarse) return "R3";
    return "R2";
  endfunction

  initial begin
    #(20ns * 100000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 16'sd0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check(fault, 1'b1, "R1 flag high in reset");

    // R9: release reset, then count good edges.
    rst_n = 1'b1;
    repeat (SETTLE - 1) @(negedge clk);
    check(fault, 1'b1, "R9 still high one edge before window ends");
    @(negedge clk);
    check(fault, 1'b0, "R9 clear on the final window edge");

    // Vector table walk.
    for (int i = 0; i < NVEC; i++) begin
      settle("R10 settled before vector");
      drive(VTAB[i].coarse, VTAB[i].err, VTAB[i].los, VTAB[i].lor, VTAB[i].ovr);
      @(negedge clk);
      check(fault, VTAB[i].exp_fault, vtag(VTAB[i]));
    end

    // R8: an interrupted good run restarts the window.
    settle("R8 settled");
    drive(1'b0, 16'sd900, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check(fault, 1'b1, "R8 raised by large step");
    drive(1'b0, 16'sd10, 1'b0, 1'b0, 1'b0);
    repeat (SETTLE - 1) @(negedge clk);
    check(fault, 1'b1, "R8 high one edge short of the window");
    drive(1'b0, 16'sd0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    drive(1'b0, 16'sd10, 1'b0, 1'b0, 1'b0);
    repeat (SETTLE - 1) @(negedge clk);
    check(fault, 1'b1, "R8 window restarted by one bad sample");
    @(negedge clk);
    check(fault, 1'b0, "R8 clear after full window");

    // R7: flag holds while the alarm persists.
    drive(1'b0, 16'sd0, 1'b0, 1'b0, 1'b1);
    repeat (40) @(negedge clk);
    check(fault, 1'b1, "R7 held through long alarm");

    // R3 then R2: a mode change alone can raise the flag.
    drive(1'b1, 16'sd600, 1'b0, 1'b0, 1'b0);
    repeat (SETTLE + 1) @(negedge clk);
    check(fault, 1'b0, "R3 600 clean in coarse mode");
    drive(1'b0, 16'sd600, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check(fault, 1'b1, "R2 600 faults in fine mode");

    // R1: asynchronous reset mid-cycle.
    settle("R10 settled before async reset");
    #5;
    rst_n = 1'b0;
    #1;
    check(fault, 1'b1, "R1 async set without a clock edge");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (SETTLE) @(negedge clk);
    check(fault, 1'b0, "R9 clear after second reset window");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule